// File: doc/BRIEF.md
# Selectable Correctable-Error Counter

This block keeps a running tally of correctable errors for one cluster, so that a slow management controller can poll it now and then and work out how fast errors arise. Eight error-type inputs come in from the cluster's error logic. A selection register picks which of them take part. The selected inputs are OR-combined into a single enable, so the counter advances by at most one per clock, however many selected errors fire in that cycle.

The tally is a 7-bit count that stops at its maximum value. It is paired with a sticky overflow flag. A single-bit register port gives access to both registers. Address 0 holds the selection mask, and it is written directly. Address 1 holds the status word: count in bits [6:0], overflow in bit [7]. Its bits are cleared by writing 1s. Read data follows the address combinationally.

Top module: `cerr_counter`

## Requirements
- R1: After reset, the selection mask reads 0 and the status word (overflow and count) reads 0.
- R2: A write to address 0 stores the write data as the selection mask, readable from the next cycle. Without such a write, the mask is held.
- R3: In a cycle where at least one error input with its mask bit set is high, the count rises by exactly one, whatever the number of such inputs.
- R4: Error inputs whose mask bit is 0 have no effect on the count. A mask of 0 disables counting.
- R5: An event at count 127 leaves the count at 127 and sets the overflow flag (status bit 7).
- R6: Once set, the overflow flag stays set until a write to address 1 has bit 7 set. Clearing the count bits alone leaves it set.
- R7: A write to address 1 clears each status bit whose write-data bit is 1 and leaves the others unchanged. Writing all zeros changes nothing.
- R8: When a write to address 1 and a selected event fall in the same cycle, the write takes precedence and that cycle's event is not counted. Later events count from the value left by the write.
- R9: A selected event in the same cycle as a mask write is judged against the mask held before the write.
- R10: Read data shows the mask when the address is 0, and the status word when the address is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_in | input | 8 | One correctable-error pulse per error type |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = selection mask, 1 = status word |
| reg_wdata | input | 8 | Write data (mask value, or write-1-to-clear bits) |
| reg_rdata | output | 8 | Read data for the addressed register |

## Verification
A sweep applies every one of the 256 error-input patterns to a cleared counter, under each single-bit mask, an all-ones mask, a zero mask and a sparse mask. This shows that only the selected inputs count and that coincident errors add just one. A long burst drives the count past 127 to expose saturation and overflow. Partial clear patterns then separate the independent clearing of the count bits from that of the overflow bit. Events that coincide with status or mask writes tell apart the clear-wins and old-mask orderings from any other ordering.

// File: rtl/errcnt_pkg.sv
`timescale 1ns/1ps
package errcnt_pkg;
  typedef enum logic {
    REG_SEL  = 1'b0,
    REG_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/errcnt_sel.sv
`timescale 1ns/1ps
module errcnt_sel #(
  parameter int NUM_TYPES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_wr,
  input  logic [NUM_TYPES-1:0] sel_wdata,
  input  logic [NUM_TYPES-1:0] err_in,
  output logic [NUM_TYPES-1:0] sel_q,
  output logic                 hit
);
  logic [NUM_TYPES-1:0] gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_wr) sel_q <= sel_wdata;
  end

  for (genvar g = 0; g < NUM_TYPES; g++) begin : g_gate
    assign gated[g] = err_in[g] & sel_q[g];
  end

  assign hit = |gated;

  assert_sel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> $stable(sel_q));
  assert_zero_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0) |-> !hit);
endmodule

// File: rtl/errcnt_core.sv
`timescale 1ns/1ps
module errcnt_core #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             clr_wr,
  input  logic [CNT_W:0]   clr_mask,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             at_max,
  output logic             bump
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] w1c(input logic [CNT_W-1:0] c,
                                           input logic [CNT_W-1:0] m);
    return c & ~m;
  endfunction

  logic [CNT_W-1:0] nxt_cnt;
  logic             nxt_ovf;

  assign at_max = (cnt == CNT_MAX);
  assign bump   = hit && !clr_wr;

  always_comb begin
    nxt_cnt = cnt;
    nxt_ovf = ovf;
    if (clr_wr) begin
      nxt_cnt = w1c(cnt, clr_mask[CNT_W-1:0]);
      nxt_ovf = ovf & ~clr_mask[CNT_W];
    end else if (hit) begin
      nxt_cnt = sat_inc(cnt);
      nxt_ovf = ovf | at_max;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      cnt <= nxt_cnt;
      ovf <= nxt_ovf;
    end
  end

  assert_one_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bump && !at_max |=> (cnt == $past(cnt) + CNT_W'(1)));
  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr && !hit |=> $stable(cnt) && $stable(ovf));
  assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bump && at_max |=> (cnt == CNT_MAX) && ovf);
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !(clr_wr && clr_mask[CNT_W]) |=> ovf);
  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((cnt & $past(clr_mask[CNT_W-1:0])) == '0));
endmodule

// File: rtl/cerr_counter.sv
`timescale 1ns/1ps
module cerr_counter
  import errcnt_pkg::*;
#(
  parameter  int NUM_TYPES = 8,
  parameter  int CNT_W     = 7,
  localparam int STAT_W    = CNT_W + 1,
  localparam int REG_W     = (NUM_TYPES > STAT_W) ? NUM_TYPES : STAT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_TYPES-1:0] err_in,
  input  logic                 reg_wr,
  input  logic                 reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata
);
  logic                 sel_wr;
  logic                 clr_wr;
  logic                 hit;
  logic [NUM_TYPES-1:0] sel_q;
  logic [CNT_W-1:0]     cnt;
  logic                 ovf;
  logic                 at_max;
  logic                 bump;
  reg_sel_e             target;

  assign target = reg_sel_e'(reg_addr);
  assign sel_wr = reg_wr && (target == REG_SEL);
  assign clr_wr = reg_wr && (target == REG_STAT);

  errcnt_sel #(.NUM_TYPES(NUM_TYPES)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_wr    (sel_wr),
    .sel_wdata (reg_wdata[NUM_TYPES-1:0]),
    .err_in    (err_in),
    .sel_q     (sel_q),
    .hit       (hit)
  );

  errcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .clr_wr   (clr_wr),
    .clr_mask (reg_wdata[CNT_W:0]),
    .cnt      (cnt),
    .ovf      (ovf),
    .at_max   (at_max),
    .bump     (bump)
  );

  always_comb begin
    reg_rdata = '0;
    if (target == REG_STAT) reg_rdata[STAT_W-1:0]    = {ovf, cnt};
    else                    reg_rdata[NUM_TYPES-1:0] = sel_q;
  end

  assert_mask_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (sel_q == $past(reg_wdata[NUM_TYPES-1:0])));
endmodule

// File: tb/test_cerr_counter.sv
`timescale 1ns/1ps
module test_cerr_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] err_in = '0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] m_sel = '0;
  logic [6:0] m_cnt = '0;
  logic       m_ovf = 1'b0;

  always #4 clk = ~clk;

  cerr_counter i_cerr_counter (
    .clk(clk), .rst_n(rst_n), .err_in(err_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // One clock of stimulus; the model advances at the same edge.
  task automatic step(input logic [7:0] e, input logic w, input logic a, input logic [7:0] d);
    @(negedge clk);
    err_in = e; reg_wr = w; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (w && a) begin
      m_cnt = m_cnt & ~d[6:0];
      m_ovf = m_ovf & ~d[7];
    end else if ((e & m_sel) != 8'h00) begin
      if (m_cnt == 7'd127) m_ovf = 1'b1;
      else m_cnt = m_cnt + 7'd1;
    end
    if (w && !a) m_sel = d;
  endtask

  // Read both registers through the port (R10) and compare with the model.
  task automatic look(input string tag);
    @(negedge clk);
    err_in = '0; reg_wr = 1'b0; reg_addr = 1'b0;
    #1 chk({tag, "/R10 mask"}, reg_rdata, m_sel);
    reg_addr = 1'b1;
    #1 chk({tag, "/R10 status"}, reg_rdata, {m_ovf, m_cnt});
  endtask

  function automatic logic [7:0] mask_of(input int i);
    if (i < 8)  return 8'h01 << i;
    if (i == 8) return 8'hFF;
    if (i == 9) return 8'h00;
    return 8'hA5;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1 mask", reg_rdata, 8'h00);
    reg_addr = 1'b1;
    #1 chk("R1 status", reg_rdata, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    // Zero mask after reset: an error must not count (R1, R4).
    step(8'hFF, 0, 0, 0);
    look("R1 R4 idle");

    // Sweep all error patterns under several masks (R2, R3, R4).
    for (int s = 0; s < 11; s++) begin
      step(8'h00, 1, 0, mask_of(s));
      look("R2 mask write");
      for (int e = 0; e < 256; e++) begin
        step(8'h00, 1, 1, 8'hFF);
        step(8'(e), 0, 0, 0);
        look(((8'(e) & m_sel) != 0) ? "R3 sweep" : "R4 sweep");
      end
    end

    // Burst of simultaneous errors: one count per cycle (R3).
    step(8'h00, 1, 0, 8'hFF);
    step(8'h00, 1, 1, 8'hFF);
    for (int k = 0; k < 5; k++) step(8'hFF, 0, 0, 0);
    look("R3 burst");
    chk("R3 burst count", reg_rdata, 8'h05);

    // Saturation and overflow (R5).
    for (int k = 0; k < 122; k++) step(8'h10, 0, 0, 0);
    look("R5 at 127");
    chk("R5 max no ovf", reg_rdata, 8'h7F);
    step(8'h10, 0, 0, 0);
    step(8'h01, 0, 0, 0);
    look("R5 saturate");
    chk("R5 ovf set", reg_rdata, 8'hFF);

    // Clear count only: overflow stays (R6); then clear overflow.
    step(8'h00, 1, 1, 8'h7F);
    look("R6 count cleared");
    chk("R6 ovf kept", reg_rdata, 8'h80);
    step(8'h02, 0, 0, 0);
    look("R6 counts on");
    step(8'h00, 1, 1, 8'h80);
    look("R6 ovf cleared");
    chk("R6 ovf gone", reg_rdata, 8'h01);

    // Partial write-1 clear and all-zero write (R7).
    for (int k = 0; k < 84; k++) step(8'h40, 0, 0, 0);
    look("R7 reach 0x55");
    chk("R7 setup", reg_rdata, 8'h55);
    step(8'h00, 1, 1, 8'h05);
    look("R7 partial");
    chk("R7 partial value", reg_rdata, 8'h50);
    step(8'h00, 1, 1, 8'h00);
    look("R7 zero write");
    chk("R7 zero write value", reg_rdata, 8'h50);

    // Clear coincides with event: clear wins, event dropped (R8).
    step(8'h00, 1, 1, 8'hFF);
    step(8'h01, 0, 0, 0);
    step(8'h01, 0, 0, 0);
    step(8'h01, 0, 0, 0);
    step(8'h01, 1, 1, 8'h01);
    look("R8 same cycle");
    chk("R8 value", reg_rdata, 8'h02);
    step(8'h01, 1, 1, 8'h7F);
    step(8'h01, 0, 0, 0);
    look("R8 from zero");
    chk("R8 restart", reg_rdata, 8'h01);

    // Event during a mask write uses the old mask (R9).
    step(8'h00, 1, 1, 8'hFF);
    step(8'h00, 1, 0, 8'h01);
    step(8'h02, 1, 0, 8'h02);
    look("R9 old mask excludes");
    chk("R9 not counted", reg_rdata, 8'h00);
    step(8'h02, 1, 0, 8'h04);
    look("R9 old mask includes");
    chk("R9 counted", reg_rdata, 8'h01);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule